// File: doc/BRIEF.md
# Timer Compare/Capture Channel Unit

This block is a single channel of a 16-bit timer. The counter and its count-clock enable come from outside the channel. Register A has two roles. In compare mode it is matched against the counter, together with register B, and the two match events shape a waveform output. In capture mode register A latches the counter value whenever the capture input shows the edge that the control field selects.

Software reaches three registers through a simple port set: a single-cycle write strobe with an address, plus a combinational read path. Those registers are a control word and the two data registers. When output shaping is on, compare events set, clear or toggle an internal waveform bit. An optional inversion is applied to that bit before it reaches the pin.

Top module: `tmr_ccu`

## Requirements
- R1: After a synchronous reset, the control word, register A and register B all read 0, and `wave_out` is 0.
- R2: The write address selects the target: 0 is control, 1 is register A, 2 is register B. A write shows on `rd_data` from the next cycle on. The control word has these fields: bit 0 is the capture-mode select, bits 2:1 are the edge code, bits 4:3 are the waveform mode and bit 5 is the invert bit. Control bits above bit 5 read 0, and address 3 reads 0.
- R3: A compare event for register A (or B) happens in a cycle where `cnt_en` is 1 and `cnt_val` equals that register. The waveform bit changes at the clock edge that ends that cycle. With `cnt_en` at 0 there is no event.
- R4: Waveform mode 1 sets the bit on a compare A event and clears it on a compare B event. When both events occur in the same cycle, the clear wins.
- R5: Waveform mode 2 toggles the bit on a compare A event and ignores compare B.
- R6: Waveform mode 3 toggles the bit on a compare B event and ignores compare A.
- R7: In waveform mode 0 the waveform bit is held at 0, so `wave_out` equals the invert bit.
- R8: In compare mode, `wave_out` is the waveform bit XOR the invert bit.
- R9: In capture mode, `wave_out` is 0 and compare events have no effect, whatever the waveform mode and invert bit are.
- R10: In capture mode, edge code 1 captures on rising edges of `cap_in`, code 2 on falling edges and code 3 on both. A change of `cap_in` ahead of clock edge k loads register A at edge k+2, with the `cnt_val` present at that edge.
- R11: Register A is never loaded by a capture when the edge code is 0 or when the channel is in compare mode.
- R12: A capture and a write to register A in the same cycle leave the captured counter value in register A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count-clock enable; compare events need it high |
| cnt_val | input | 16 | Current counter value |
| cap_in | input | 1 | Asynchronous capture trigger input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write target (0 control, 1 A, 2 B) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read select, same map as writes |
| rd_data | output | 16 | Combinational read data |
| wave_out | output | 1 | Waveform output after polarity |

## Verification
Register writes and compare events each take effect on the clock edge that ends their cycle. The bench drives inputs on the falling edge, updates its model for the following rising edge, and samples 1 ns after that edge. A capture lands two edges after the first edge that sees the new `cap_in` level. The bench therefore holds one counter value through the first two edges and checks that register A has not yet changed. It then presents a second counter value and confirms that exactly that value is stored at the third edge. The same-cycle write is placed on that third edge.

// File: rtl/tmr_ccu_pkg.sv
package tmr_ccu_pkg;

    localparam int CTRL_W = 6;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_A    = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_B    = 2'd2;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } cap_edge_e;

    typedef enum logic [1:0] {
        WAVE_OFF    = 2'd0,
        WAVE_SETCLR = 2'd1,
        WAVE_TOGA   = 2'd2,
        WAVE_TOGB   = 2'd3
    } wave_mode_e;

    typedef struct packed {
        logic       invert;
        wave_mode_e wmode;
        cap_edge_e  cedge;
        logic       capture;
    } ccu_ctrl_t;

    function automatic logic wave_next(wave_mode_e m, logic cur, logic hit_a, logic hit_b);
        logic nxt;
        case (m)
            WAVE_SETCLR: nxt = hit_b ? 1'b0 : (hit_a ? 1'b1 : cur);
            WAVE_TOGA:   nxt = hit_a ? ~cur : cur;
            WAVE_TOGB:   nxt = hit_b ? ~cur : cur;
            default:     nxt = 1'b0;
        endcase
        return nxt;
    endfunction

    function automatic logic edge_hit(cap_edge_e e, logic rise, logic fall);
        logic hit;
        case (e)
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_BOTH: hit = rise | fall;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/ccu_capture.sv
module ccu_capture #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cap_in,
    output logic rise_o,
    output logic fall_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   level;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= cap_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], cap_in};
            end
        end
    endgenerate

    assign level = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level;
    end

    assign rise_o = level & ~prev_q;
    assign fall_o = ~level & prev_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o); // R10
    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o); // R10
endmodule

// File: rtl/ccu_regs.sv
module ccu_regs
    import tmr_ccu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [W-1:0]      cnt_val,
    input  logic              rise,
    input  logic              fall,
    output ccu_ctrl_t         ctrl_q,
    output logic [W-1:0]      reg_a,
    output logic [W-1:0]      reg_b,
    output logic [W-1:0]      rd_data
);
    logic cap_fire;
    logic wr_ctrl, wr_a, wr_b;

    assign wr_ctrl  = wr_en && (wr_addr == ADDR_CTRL);
    assign wr_a     = wr_en && (wr_addr == ADDR_A);
    assign wr_b     = wr_en && (wr_addr == ADDR_B);
    assign cap_fire = ctrl_q.capture && edge_hit(ctrl_q.cedge, rise, fall);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            reg_a  <= '0;
            reg_b  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ccu_ctrl_t'(wr_data[CTRL_W-1:0]);
            if (cap_fire)  reg_a <= cnt_val;
            else if (wr_a) reg_a <= wr_data;
            if (wr_b) reg_b <= wr_data;
        end
    end

    always_comb begin
        case (rd_addr)
            ADDR_CTRL: rd_data = {{(W-CTRL_W){1'b0}}, ctrl_q};
            ADDR_A:    rd_data = reg_a;
            ADDR_B:    rd_data = reg_b;
            default:   rd_data = '0;
        endcase
    end

    AST_A_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!cap_fire && !wr_a) |=> $stable(reg_a)); // R11
    AST_CAP_WINS: assert property (@(posedge clk) disable iff (rst)
        cap_fire |=> (reg_a == $past(cnt_val))); // R12
endmodule

// File: rtl/ccu_wave.sv
module ccu_wave
    import tmr_ccu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  ccu_ctrl_t    ctrl,
    input  logic         cnt_en,
    input  logic [W-1:0] cnt_val,
    input  logic [W-1:0] reg_a,
    input  logic [W-1:0] reg_b,
    output logic         wave_out
);
    logic hit_a, hit_b;
    logic state_q, state_d;

    assign hit_a = cnt_en && (cnt_val == reg_a);
    assign hit_b = cnt_en && (cnt_val == reg_b);

    always_comb begin
        if (ctrl.capture) state_d = 1'b0;
        else              state_d = wave_next(ctrl.wmode, state_q, hit_a, hit_b);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= 1'b0;
        else     state_q <= state_d;
    end

    assign wave_out = ctrl.capture ? 1'b0 : (state_q ^ ctrl.invert);

    AST_OFF_HOLDS_LOW: assert property (@(posedge clk) disable iff (rst)
        (ctrl.capture || ctrl.wmode == WAVE_OFF) |=> !state_q); // R7
    AST_SETCLR_B_WINS: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.capture && ctrl.wmode == WAVE_SETCLR && hit_b) |=> !state_q); // R4
    AST_TOGA_FLIPS: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.capture && ctrl.wmode == WAVE_TOGA && hit_a) |=> (state_q != $past(state_q))); // R5
    AST_TOGB_FLIPS: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.capture && ctrl.wmode == WAVE_TOGB && hit_b) |=> (state_q != $past(state_q))); // R6
    AST_NO_EVENT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.capture && ctrl.wmode != WAVE_OFF && !hit_a && !hit_b) |=> $stable(state_q)); // R3
endmodule

// File: rtl/tmr_ccu.sv
module tmr_ccu
    import tmr_ccu_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en,
    input  logic [W-1:0]      cnt_val,
    input  logic              cap_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data,
    output logic              wave_out
);
    ccu_ctrl_t    ctrl;
    logic [W-1:0] reg_a, reg_b;
    logic         rise, fall;

    ccu_capture #(.SYNC_STAGES(SYNC_STAGES)) u_capture (
        .clk    (clk),
        .rst    (rst),
        .cap_in (cap_in),
        .rise_o (rise),
        .fall_o (fall)
    );

    ccu_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .cnt_val (cnt_val),
        .rise    (rise),
        .fall    (fall),
        .ctrl_q  (ctrl),
        .reg_a   (reg_a),
        .reg_b   (reg_b),
        .rd_data (rd_data)
    );

    ccu_wave #(.W(W)) u_wave (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl),
        .cnt_en   (cnt_en),
        .cnt_val  (cnt_val),
        .reg_a    (reg_a),
        .reg_b    (reg_b),
        .wave_out (wave_out)
    );

    AST_CAPMODE_PIN_LOW: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_CTRL && wr_data[0]) |=> !wave_out); // R9
endmodule

// File: tb/test_tmr_ccu.sv
module test_tmr_ccu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b0;
    logic [15:0] cnt_val = '0;
    logic        cap_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        wave_out;

    int checks = 0;
    int errors = 0;

    // bench model of the registers and waveform bit
    logic [5:0]  m_ctrl = '0;
    logic [15:0] m_a = '0;
    logic [15:0] m_b = '0;
    logic        m_state = 1'b0;

    always #4 clk = ~clk;

    tmr_ccu i_tmr_ccu (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .cnt_val(cnt_val), .cap_in(cap_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .wave_out(wave_out)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_next(logic [5:0] c, logic cur, logic ha, logic hb);
        if (c[0]) return 1'b0;
        case (c[4:3])
            2'd1:    return hb ? 1'b0 : (ha ? 1'b1 : cur);
            2'd2:    return ha ? ~cur : cur;
            2'd3:    return hb ? ~cur : cur;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic exp_pin(logic [5:0] c, logic st);
        return c[0] ? 1'b0 : (st ^ c[5]);
    endfunction

    // one cycle starting just after a falling edge; returns just after the next falling edge
    task automatic cycle(input logic en, input logic [15:0] val, input logic we,
                         input logic [1:0] wa, input logic [15:0] wd, input string req);
        logic ha, hb;
        cnt_en = en; cnt_val = val;
        wr_en = we; wr_addr = wa; wr_data = wd;
        ha = en && (val == m_a);
        hb = en && (val == m_b);
        m_state = exp_next(m_ctrl, m_state, ha, hb);
        if (we) begin
            if (wa == 2'd0) m_ctrl = wd[5:0];
            if (wa == 2'd1) m_a = wd;
            if (wa == 2'd2) m_b = wd;
        end
        @(posedge clk); #1;
        chk(req, {15'd0, wave_out}, {15'd0, exp_pin(m_ctrl, m_state)});
        @(negedge clk);
        wr_en = 1'b0; cnt_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [15:0] exp, input string req);
        rd_addr = a; #1;
        chk(req, rd_data, exp);
    endtask

    // capture episode: cap_in changes before edge k; value V presented for edge k+2
    task automatic cap_try(input logic lvl, input logic [15:0] v, input logic expect_cap,
                           input logic do_wr, input string req);
        rd_addr = 2'd1;
        cnt_val = ~v;
        cap_in = lvl;
        @(negedge clk); @(negedge clk);
        #1 chk(req, rd_data, m_a);
        cnt_val = v;
        if (do_wr) begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'hD00D; end
        @(posedge clk); #1;
        wr_en = 1'b0;
        if (expect_cap) m_a = v;
        else if (do_wr) m_a = 16'hD00D;
        chk(req, rd_data, m_a);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd_chk(2'd0, 16'h0000, "R1 ctrl");
        rd_chk(2'd1, 16'h0000, "R1 regA");
        rd_chk(2'd2, 16'h0000, "R1 regB");
        chk("R1 wave", {15'd0, wave_out}, 16'd0);
        @(negedge clk);

        // R2 register map
        cycle(0, 0, 1, 2'd1, 16'h1234, "R2 wrA");
        rd_chk(2'd1, 16'h1234, "R2 regA");
        cycle(0, 0, 1, 2'd2, 16'hABCD, "R2 wrB");
        rd_chk(2'd2, 16'hABCD, "R2 regB");
        cycle(0, 0, 1, 2'd0, 16'hFFC6, "R2 wrCtrl");
        rd_chk(2'd0, 16'h0006, "R2 ctrl upper bits");
        rd_chk(2'd3, 16'h0000, "R2 addr3");
        @(negedge clk);

        // R3 enable gating, mode 2 (ctrl 0x10)
        cycle(0, 0, 1, 2'd0, 16'h0010, "R3 setup");
        cycle(0, 0, 1, 2'd1, 16'h0005, "R3 setup");
        cycle(0, 16'h0005, 0, 0, 0, "R3 no enable no event");
        cycle(1, 16'h0005, 0, 0, 0, "R3 enabled event toggles");
        chk("R3 toggled high", {15'd0, wave_out}, 16'd1);

        // R4 both at once in mode 1: clear wins
        cycle(0, 0, 1, 2'd0, 16'h0008, "R4 setup");
        cycle(1, 16'h0005, 0, 0, 0, "R4 set on A");
        chk("R4 high after A", {15'd0, wave_out}, 16'd1);
        cycle(0, 0, 1, 2'd2, 16'h0005, "R4 setup B");
        cycle(1, 16'h0005, 0, 0, 0, "R4 B wins");
        chk("R4 low after A+B", {15'd0, wave_out}, 16'd0);

        // R7 / R8 off mode shows invert
        cycle(0, 0, 1, 2'd0, 16'h0020, "R7 off inverted");
        chk("R7 pin equals invert", {15'd0, wave_out}, 16'd1);
        cycle(1, 16'h0005, 0, 0, 0, "R7 off ignores events");

        // R9 capture mode quiets the pin
        cycle(0, 0, 1, 2'd0, 16'h0031, "R9 capture mode");
        cycle(1, 16'h0005, 0, 0, 0, "R9 compares ignored");
        chk("R9 pin low", {15'd0, wave_out}, 16'd0);

        // random compare-mode traffic: R3..R8
        for (int i = 0; i < 4000; i++) begin
            logic we;
            logic [1:0] wa;
            logic [15:0] wd;
            string tag;
            we = ($urandom % 8) == 0;
            wa = 2'($urandom % 3);
            wd = (wa == 2'd0) ? {10'd0, 6'($urandom) & 6'h3E} : 16'($urandom % 4);
            case (m_ctrl[4:3])
                2'd0: tag = "R7 random";
                2'd1: tag = "R4 random";
                2'd2: tag = "R5 random";
                default: tag = "R6 random";
            endcase
            if (m_ctrl[5]) tag = {tag, " R8 inverted"};
            cycle(($urandom % 4) != 0, 16'($urandom % 4), we, wa, wd, tag);
        end

        // capture edge selection R10, R11, R12
        cycle(0, 0, 1, 2'd0, 16'h0003, "R10 rise code");
        cap_try(1'b1, 16'h1111, 1'b1, 1'b0, "R10 rise captured");
        cap_try(1'b0, 16'h2222, 1'b0, 1'b0, "R10 fall ignored on rise code");
        cycle(0, 0, 1, 2'd0, 16'h0005, "R10 fall code");
        cap_try(1'b1, 16'h3333, 1'b0, 1'b0, "R10 rise ignored on fall code");
        cap_try(1'b0, 16'h4444, 1'b1, 1'b0, "R10 fall captured");
        cycle(0, 0, 1, 2'd0, 16'h0007, "R10 both code");
        cap_try(1'b1, 16'h5555, 1'b1, 1'b0, "R10 both rise");
        cap_try(1'b0, 16'h6666, 1'b1, 1'b0, "R10 both fall");
        cycle(0, 0, 1, 2'd0, 16'h0001, "R11 code 0");
        cap_try(1'b1, 16'h7777, 1'b0, 1'b0, "R11 code 0 rise");
        cap_try(1'b0, 16'h8888, 1'b0, 1'b0, "R11 code 0 fall");
        cycle(0, 0, 1, 2'd0, 16'h0006, "R11 compare mode");
        cap_try(1'b1, 16'h9999, 1'b0, 1'b0, "R11 compare mode rise");
        cap_try(1'b0, 16'hAAAA, 1'b0, 1'b0, "R11 compare mode fall");
        cycle(0, 0, 1, 2'd0, 16'h0003, "R12 setup");
        cap_try(1'b1, 16'hBEEF, 1'b1, 1'b1, "R12 capture beats write");
        cap_try(1'b0, 16'hCAFE, 1'b0, 1'b1, "R12 write lands without capture");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule